// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of external interrupt request lines for a small CPU core and decides which one the core should take next. Each line goes through a two-stage synchronizer and a rising-edge detector. A detected edge sets that line's pending bit, and the bit stays set until the core accepts the request, even if the line has already dropped. Software writes a mask word through a simple write port and can read it back. Among the pending lines that are not masked, the block presents the most important one on `cpu_irq`, with its index on `cpu_vector`. The core uses that index to look up the handler address in its vector table.

The core samples `cpu_irq` at instruction boundaries. When it takes the interrupt, it pulses `cpu_ack`, which moves the presented line from pending to in-service. At the end of the handler it pulses `cpu_eoi`, which retires the most important in-service level. While a handler runs, only a strictly more important line can raise `cpu_irq` again, so handlers nest by priority. Less important and equal requests stay pending until the levels above them retire. Line 0 has the highest priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, no line is pending or in service, `cpu_irq` is low, and every line is masked (`mask_rdata` reads all ones).
- R2: A rising edge on `irq_in[i]` makes line i pending three clock edges after the input rises. The line stays pending after the input falls, until it is acknowledged.
- R3: A clock edge with `mask_we` high loads `mask_wdata` into the mask, and `mask_rdata` shows the new mask. A bit value of 1 masks its line. A masked pending line is not presented, but it stays pending.
- R4: When `cpu_irq` is high, `cpu_vector` is the lowest index among lines that are pending and unmasked.
- R5: A clock edge with `cpu_ack` high while `cpu_irq` is high clears the pending bit of line `cpu_vector` and sets its in-service bit.
- R6: A candidate whose index is equal to or greater than the lowest in-service index does not raise `cpu_irq`, and it stays pending.
- R7: A candidate whose index is strictly lower than every in-service index raises `cpu_irq`, which preempts the running handler.
- R8: A clock edge with `cpu_eoi` high clears only the lowest-index in-service bit. This lets the next lower level be presented.
- R9: A new edge on a line in the same cycle as the acknowledge of that line leaves the line pending, so the new event is not lost.
- R10: A `cpu_ack` while `cpu_irq` is low changes no pending or in-service state.
- R11: A line held high produces exactly one event. It does not raise a new request after it has been serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | N_LINES | Asynchronous request lines, bit 0 has the highest priority |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | N_LINES | Mask value to load, 1 masks the line |
| mask_rdata | output | N_LINES | Current mask |
| cpu_irq | output | 1 | Interrupt request to the core |
| cpu_vector | output | $clog2(N_LINES) | Index of the presented line |
| cpu_ack | input | 1 | Core takes the presented interrupt |
| cpu_eoi | input | 1 | Core finished the current handler |

## Verification
The checks on `cpu_ack` and `cpu_eoi` assume that the core pulses each strobe for one cycle. The ack check also assumes that the core acknowledges only while `cpu_irq` is high, and the EOI check excludes cycles where an ack lands at the same time. The directed stimulus follows the core's protocol: every ack is one cycle wide, and every EOI pairs with an earlier ack. The random phase adds stray acks while `cpu_irq` is low and EOIs with nothing in service, so that the ignore paths are also compared against the bench model. Request lines are driven on the falling edge and held for at least one rising edge, so each intended pulse is seen by the synchronizer.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg: shared constants for the interrupt controller.
// Assumes nothing beyond a line count of at least two.
package irqc_pkg;
    parameter int unsigned IRQC_DEF_LINES = 8;
    parameter int unsigned IRQC_SYNC_STAGES = 2;
endpackage

// File: rtl/irqc_edge_sync.sv
// Module irqc_edge_sync: per-line two-flop synchronizer followed by a
// rising-edge detector. rise[i] is high for one cycle per input rise.
// Assumes each input pulse is held across at least one rising clock edge.
module irqc_edge_sync #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic meta_q, stab_q, last_q;

        // Synchronize the line and keep the previous synchronized value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
                last_q <= stab_q;
            end
        end

        // A low-to-high change of the synchronized value marks one event.
        assign rise[g] = stab_q & ~last_q;
    end
endmodule

// File: rtl/irqc_pick.sv
// Module irqc_pick: fixed-priority finder, the lowest set index wins.
// Assumes nothing about how many request bits are set.
module irqc_pick #(
    parameter int unsigned N   = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set index is kept last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module prio_irq_ctrl: nested fixed-priority interrupt controller.
// Latches synchronized edges as pending, applies a software mask, presents
// the best candidate that beats every in-service level, and moves a line
// to in-service on acknowledge. End-of-service retires the top level.
// Assumes one-cycle ack and EOI strobes from the core.
module prio_irq_ctrl #(
    parameter int unsigned N_LINES = irqc_pkg::IRQC_DEF_LINES,
    localparam int unsigned VW     = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               mask_we,
    input  logic [N_LINES-1:0] mask_wdata,
    output logic [N_LINES-1:0] mask_rdata,
    output logic               cpu_irq,
    output logic [VW-1:0]      cpu_vector,
    input  logic               cpu_ack,
    input  logic               cpu_eoi
);
    localparam logic [N_LINES-1:0] ONE = {{(N_LINES-1){1'b0}}, 1'b1};

    logic [N_LINES-1:0] pend_q, isr_q, mask_q;
    logic [N_LINES-1:0] edge_rise, cand, take_bit, done_bit;
    logic               cand_found, act_found, take;
    logic [VW-1:0]      cand_idx, act_idx;

    irqc_edge_sync #(.N(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .rise(edge_rise)
    );

    assign cand = pend_q & ~mask_q;

    irqc_pick #(.N(N_LINES)) u_cand (.req(cand),  .found(cand_found), .idx(cand_idx));
    irqc_pick #(.N(N_LINES)) u_act  (.req(isr_q), .found(act_found),  .idx(act_idx));

    // Present the candidate only if it outranks every active level.
    always_comb begin
        cpu_irq  = cand_found && (!act_found || (cand_idx < act_idx));
        take     = cpu_ack && cpu_irq;
        take_bit = take ? (ONE << cand_idx) : '0;
        done_bit = (cpu_eoi && act_found) ? (ONE << act_idx) : '0;
    end

    assign cpu_vector = cand_idx;
    assign mask_rdata = mask_q;

    // Pending: clear on acknowledge, and a new edge in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~take_bit) | edge_rise;
    end

    // In-service: set on acknowledge, retire the top level on EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~done_bit) | take_bit;
    end

    // Mask register: loaded by software, all lines masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end
endmodule

// File: rtl/irqc_checker.sv
// Module irqc_checker: protocol and state properties of prio_irq_ctrl.
// Assumes one-cycle ack and EOI strobes; attached by bind below.
module irqc_checker #(
    parameter int unsigned N = 8,
    localparam int unsigned VW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_ack,
    input logic          cpu_eoi,
    input logic          cpu_irq,
    input logic [VW-1:0] cpu_vector,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  pend_q,
    input logic [N-1:0]  isr_q,
    input logic [N-1:0]  edge_rise
);
    logic [N-1:0] at_vec, at_or_above;
    assign at_vec      = {{(N-1){1'b0}}, 1'b1} << cpu_vector;
    assign at_or_above = (at_vec - 1'b1) | at_vec;

    a_r4_vec_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (pend_q[cpu_vector] && !mask_q[cpu_vector]));

    a_r6_beats_active: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((isr_q & at_or_above) == '0));

    a_r5_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq) |=> isr_q[$past(cpu_vector)]);

    a_r8_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_eoi && !cpu_ack && (isr_q != '0)) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    a_r9_rise_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise != '0) |=> ((pend_q & $past(edge_rise)) == $past(edge_rise)));
endmodule

bind prio_irq_ctrl irqc_checker #(.N(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi),
    .cpu_irq(cpu_irq), .cpu_vector(cpu_vector), .mask_q(mask_q),
    .pend_q(pend_q), .isr_q(isr_q), .edge_rise(edge_rise)
);

// File: tb/tb_prio_irq_ctrl.sv
// Bench tb_prio_irq_ctrl: directed scenarios plus a random phase, with a
// behavioural model compared against the outputs on every falling edge.
module tb_prio_irq_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic [N-1:0] mask_rdata;
    logic         cpu_irq;
    logic [2:0]   cpu_vector;
    logic         cpu_ack = 1'b0;
    logic         cpu_eoi = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_rdata(mask_rdata), .cpu_irq(cpu_irq),
        .cpu_vector(cpu_vector), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi)
    );

    // Behavioural model state
    bit m_pend[N], m_isr[N], m_mask[N];
    bit m_hist[3][N];   // input history: [0] newest

    function automatic int m_cand();
        for (int i = 0; i < N; i++) if (m_pend[i] && !m_mask[i]) return i;
        return -1;
    endfunction

    function automatic int m_top();
        for (int i = 0; i < N; i++) if (m_isr[i]) return i;
        return N;
    endfunction

    function automatic bit m_irq();
        int c = m_cand();
        return (c >= 0) && (c < m_top());
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_isr[i] = 0; m_mask[i] = 1;
                m_hist[0][i] = 0; m_hist[1][i] = 0; m_hist[2][i] = 0;
            end
        end else begin
            int c, t;
            bit fire;
            c = m_cand();
            t = m_top();
            fire = m_irq();
            if (cpu_ack && fire) begin m_pend[c] = 0; m_isr[c] = 1; end
            if (cpu_eoi && t < N) m_isr[t] = 0;
            for (int i = 0; i < N; i++) begin
                if (m_hist[1][i] && !m_hist[2][i]) m_pend[i] = 1;
                if (mask_we) m_mask[i] = mask_wdata[i];
                m_hist[2][i] = m_hist[1][i];
                m_hist[1][i] = m_hist[0][i];
                m_hist[0][i] = irq_in[i];
            end
        end
    end

    // Cycle comparison against the model (R4 selection, R6/R7 nesting)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_irq;
            logic [N-1:0] e_mask;
            e_irq = m_irq();
            for (int i = 0; i < N; i++) e_mask[i] = m_mask[i];
            checks++;
            if (cpu_irq !== e_irq || mask_rdata !== e_mask ||
                (e_irq && cpu_vector !== 3'(m_cand()))) begin
                errors++;
                $display("FAIL R4 model compare: irq=%0b vec=%0d mask=%h expected irq=%0b vec=%0d mask=%h",
                         cpu_irq, cpu_vector, mask_rdata, e_irq, m_cand(), e_mask);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic expect_out(string req, bit e_irq, int e_vec);
        checks++;
        if (cpu_irq !== e_irq || (e_irq && cpu_vector !== 3'(e_vec))) begin
            errors++;
            $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                     req, cpu_irq, cpu_vector, e_irq, e_vec);
        end
    endtask

    task automatic pulse_line(int i);
        irq_in[i] = 1'b1; tick(); irq_in[i] = 1'b0;
    endtask

    task automatic set_mask(logic [N-1:0] v);
        mask_we = 1'b1; mask_wdata = v; tick(); mask_we = 1'b0;
    endtask

    task automatic ack();  cpu_ack = 1'b1; tick(); cpu_ack = 1'b0; endtask
    task automatic eoi();  cpu_eoi = 1'b1; tick(); cpu_eoi = 1'b0; endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        checks++;
        if (cpu_irq !== 1'b0 || mask_rdata !== 8'hFF) begin
            errors++;
            $display("FAIL R1: irq=%0b mask=%h expected irq=0 mask=ff", cpu_irq, mask_rdata);
        end
        rst_n = 1'b1;
        tick(4);
        expect_out("R1 idle after reset", 0, 0);

        set_mask(8'h00);
        checks++;
        if (mask_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R3: mask=%h expected 00", mask_rdata);
        end

        // R2: short pulse is remembered
        pulse_line(5); tick(4);
        expect_out("R2 latched pulse", 1, 5);

        // R4: best of several
        irq_in[2] = 1; irq_in[6] = 1; tick(); irq_in = '0; tick(4);
        expect_out("R4 lowest index wins", 1, 2);

        // R5: ack moves line 2 to service, lower 5 and 6 blocked
        ack();
        expect_out("R5 after ack lower lines wait", 0, 0);

        // R6: equal level does not interrupt
        pulse_line(2); tick(4);
        expect_out("R6 equal level blocked", 0, 0);

        // R7: higher level preempts
        pulse_line(0); tick(4);
        expect_out("R7 higher preempts", 1, 0);
        ack();
        expect_out("R7 nested service", 0, 0);

        // R8: EOI retires the top level only
        eoi();
        expect_out("R8 level 2 still in service", 0, 0);
        eoi();
        expect_out("R8 level 2 retired", 1, 2);
        ack(); eoi();
        expect_out("R8 next is 5", 1, 5);
        ack(); eoi();
        expect_out("R8 next is 6", 1, 6);
        ack(); eoi();
        expect_out("R8 all drained", 0, 0);

        // R3: masked line held pending
        set_mask(8'h10);
        pulse_line(4); tick(4);
        expect_out("R3 masked line hidden", 0, 0);
        // R10: ack with irq low is ignored
        ack();
        set_mask(8'h00);
        expect_out("R10 pending survived stray ack", 1, 4);
        ack(); eoi();
        expect_out("R10 drained", 0, 0);

        // R11: held level yields one event
        irq_in[1] = 1; tick(4);
        expect_out("R11 first event", 1, 1);
        ack(); eoi(); tick(4);
        expect_out("R11 no repeat while held", 0, 0);
        irq_in[1] = 0; tick(4);

        // R9: new edge lands on the ack cycle
        pulse_line(3); tick(4);
        expect_out("R9 line 3 presented", 1, 3);
        irq_in[3] = 1; tick(2);
        cpu_ack = 1; tick(); cpu_ack = 0; irq_in[3] = 0;
        expect_out("R9 equal level waits", 0, 0);
        eoi();
        expect_out("R9 event kept", 1, 3);
        ack(); eoi(); tick(4);
        expect_out("R9 drained", 0, 0);

        // Random phase, checked by the model
        for (int k = 0; k < 600; k++) begin
            irq_in     = 8'($urandom) & 8'($urandom);
            cpu_ack    = ($urandom % 3) == 0;
            cpu_eoi    = ($urandom % 4) == 0;
            mask_we    = ($urandom % 16) == 0;
            mask_wdata = 8'($urandom) & 8'($urandom);
            tick();
        end
        irq_in = '0; cpu_ack = 0; cpu_eoi = 0; mask_we = 0;
        tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule